// File: doc/BRIEF.md
# Byte-Lane Memory Decoder for a 16-bit Bus

This block sits on the latched, demultiplexed bus of a processor with a 20-bit byte address and a 16-bit data path. It turns the top four address bits into selects for three 64 KB regions. One region holds a read-only pair and the other two hold read/write pairs. Every pair is two 8-bit banks. The even bank serves the low data lane and the odd bank serves the high data lane. Address bit 0 and an active-low high-byte enable pick the lanes, so one access can move a low byte, a high byte, or a full aligned word.

Each bank holds 2^BANK_AW bytes, indexed by address bits BANK_AW:1. The populated window sits at the top of each 64 KB region. At BANK_AW = 15 the window fills the whole region. Decoding is absolute: address bits 15:BANK_AW+1 must all be one, and any other address selects nothing and raises a one-cycle decode error. The read-only contents are computed, not loaded.

Top module: `memdec_top`

## Requirements
- R1: Tag 4'hD (address bits 19:16) selects RAM pair 0, 4'hE selects RAM pair 1 and 4'hF selects the ROM pair. This holds only when address bits 15:BANK_AW+1 are all one. Any other address is unmapped, reads as 16'hFFFF and changes no storage.
- R2: The even bank drives rdData[7:0] and is enabled when addr[0] is 0. The odd bank drives rdData[15:8] and is enabled when bheN is 0. With both enabled, one access transfers the whole word at bank index addr[BANK_AW:1].
- R3: On a read, a lane that is not enabled returns 8'hFF.
- R4: rdData is loaded on the clock edge where rdEn is high and holds its value otherwise. Reset sets rdData to 16'hFFFF and decErr to 0.
- R5: A write stores only the enabled lanes of the selected RAM pair, on the edge where wrEn is high. The other lane and the other pair keep their contents.
- R6: The ROM byte at index k is k[7:0] XOR 8'h3C on the even lane and k[7:0] XOR 8'hC3 on the odd lane. Writes into the ROM region change nothing and raise no error.
- R7: An access with addr[0] = 1 and bheN = 1 enables no bank. A write with this pattern modifies no storage.
- R8: decErr is high in the cycle after an edge where rdEn or wrEn was high with an unmapped address, and low in every other cycle.
- R9: When rdEn and wrEn are high together, rdData receives the contents from before the write, and the write still takes effect.
- R10: The reset fetch address 20'hFFFF0 decodes into the ROM region and reads its pattern word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Latched byte address |
| bheN | input | 1 | Active-low high-byte enable |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data, both lanes |
| rdData | output | 16 | Registered read data |
| decErr | output | 1 | One-cycle unmapped-access flag |

## Verification
A read and a write can land on the same word in the same cycle. The bench drives both strobes to a RAM word whose old value it knows. The read result must equal the old value, and a later plain read must return the new value. Decode error and read data can also change together: strobes to unmapped tags and to holes in a region must give 16'hFFFF and a single-cycle decErr. The bench checks RAM that an unmapped write might have hit in a later sweep.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_RAM0 = 2'd1,
    RG_RAM1 = 2'd2,
    RG_ROM  = 2'd3
  } region_e;

  localparam logic [3:0] TAG_RAM0 = 4'hD;
  localparam logic [3:0] TAG_RAM1 = 4'hE;
  localparam logic [3:0] TAG_ROM  = 4'hF;

  localparam logic [7:0] ROM_KEY_EVEN = 8'h3C;
  localparam logic [7:0] ROM_KEY_ODD  = 8'hC3;

  typedef struct packed {
    region_e    region;
    logic [1:0] laneEn;
    logic       rdStb;
    logic [1:0] weRam0;
    logic [1:0] weRam1;
  } busStrobes_t;

  function automatic logic [7:0] romByte(input logic oddLane, input logic [14:0] idx);
    return idx[7:0] ^ (oddLane ? ROM_KEY_ODD : ROM_KEY_EVEN);
  endfunction

endpackage

// File: rtl/memdec_bank.sv
module memdec_bank #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wrByte,
  output logic [7:0]    rdByte
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wrByte;
  end

  assign rdByte = cells[idx];
endmodule

// File: rtl/memdec_ctrl.sv
module memdec_ctrl
  import memdec_pkg::*;
#(
  parameter int BANK_AW = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] addr,
  input  logic        bheN,
  input  logic        rdEn,
  input  logic        wrEn,
  output busStrobes_t strobes,
  output logic        decErr
);
  localparam logic [15:0] LOW_MASK = 16'((32'd1 << (BANK_AW + 1)) - 32'd1);

  logic    windowHit;
  region_e region;
  logic [1:0] laneEn;

  assign windowHit = &(addr[15:0] | LOW_MASK);
  assign laneEn    = {~bheN, ~addr[0]};

  always_comb begin
    region = RG_NONE;
    if (windowHit) begin
      unique case (addr[19:16])
        TAG_RAM0: region = RG_RAM0;
        TAG_RAM1: region = RG_RAM1;
        TAG_ROM:  region = RG_ROM;
        default:  region = RG_NONE;
      endcase
    end
  end

  always_comb begin
    strobes.region = region;
    strobes.laneEn = laneEn;
    strobes.rdStb  = rdEn;
    strobes.weRam0 = (wrEn && region == RG_RAM0) ? laneEn : 2'b00;
    strobes.weRam1 = (wrEn && region == RG_RAM1) ? laneEn : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) decErr <= 1'b0;
    else       decErr <= (rdEn || wrEn) && (region == RG_NONE);
  end
endmodule

// File: rtl/memdec_datapath.sv
module memdec_datapath
  import memdec_pkg::*;
#(
  parameter int BANK_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobes_t        strobes,
  input  logic [BANK_AW-1:0] idx,
  input  logic [15:0]        wrData,
  output logic [15:0]        rdData
);
  localparam int PAIRS = 2;
  localparam int LANES = 2;

  logic [7:0]  ramByte [PAIRS][LANES];
  logic [7:0]  romLane [LANES];
  logic [15:0] nextWord;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic bankWe;
      if (p == 0) begin : g_we0
        assign bankWe = strobes.weRam0[l];
      end else begin : g_we1
        assign bankWe = strobes.weRam1[l];
      end
      memdec_bank #(.AW(BANK_AW)) u_bank (
        .clk    (clk),
        .we     (bankWe),
        .idx    (idx),
        .wrByte (wrData[8*l +: 8]),
        .rdByte (ramByte[p][l])
      );
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rom
    assign romLane[l] = romByte(l[0], 15'(idx));
  end

  always_comb begin
    nextWord = 16'hFFFF;
    for (int l = 0; l < LANES; l++) begin
      if (strobes.laneEn[l]) begin
        unique case (strobes.region)
          RG_RAM0: nextWord[8*l +: 8] = ramByte[0][l];
          RG_RAM1: nextWord[8*l +: 8] = ramByte[1][l];
          RG_ROM:  nextWord[8*l +: 8] = romLane[l];
          default: nextWord[8*l +: 8] = 8'hFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= 16'hFFFF;
    else if (strobes.rdStb) rdData <= nextWord;
  end
endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int BANK_AW = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] addr,
  input  logic        bheN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        decErr
);
  busStrobes_t        strobes;
  logic [BANK_AW-1:0] idx;

  assign idx = addr[BANK_AW:1];

  memdec_ctrl #(.BANK_AW(BANK_AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .bheN    (bheN),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .strobes (strobes),
    .decErr  (decErr)
  );

  memdec_datapath #(.BANK_AW(BANK_AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .idx     (idx),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/memdec_checker.sv
module memdec_checker
  import memdec_pkg::*;
#(
  parameter int BANK_AW = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic [19:0] addr,
  input logic        bheN,
  input logic        rdEn,
  input logic        wrEn,
  input logic [15:0] rdData,
  input logic        decErr
);
  localparam logic [15:0] FILL_MASK = 16'((32'd1 << (BANK_AW + 1)) - 32'd1);

  logic inWindow, mapped, romHit;
  assign inWindow = ((addr[15:0] | FILL_MASK) == 16'hFFFF);
  assign mapped   = inWindow && (addr[19:16] == TAG_RAM0 || addr[19:16] == TAG_RAM1 ||
                                 addr[19:16] == TAG_ROM);
  assign romHit   = inWindow && addr[19:16] == TAG_ROM;

  // R4 reset values
  p_reset_state_r4: assert property (@(posedge clk)
    !rstN |=> (rdData == 16'hFFFF && !decErr));

  // R4 hold without read
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R3 disabled lanes
  p_even_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[0]) |=> rdData[7:0] == 8'hFF);
  p_odd_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && bheN) |=> rdData[15:8] == 8'hFF);

  // R1 unmapped reads
  p_unmapped_ff_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> rdData == 16'hFFFF);

  // R6 ROM even lane contents
  p_rom_even_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && romHit && !addr[0]) |=>
      rdData[7:0] == romByte(1'b0, 15'($past(addr[BANK_AW:1]))));

  // R8 decode error
  p_decerr_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && !mapped) |=> decErr);
  p_decerr_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !((rdEn || wrEn) && !mapped) |=> !decErr);
endmodule

bind memdec_top memdec_checker #(.BANK_AW(BANK_AW)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .bheN   (bheN),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .rdData (rdData),
  .decErr (decErr)
);

// File: tb/tb_memdec_top.sv
module tb_memdec_top;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;
  localparam logic [15:0] FILL = 16'hFFFF & ~16'((32'd1 << (AW + 1)) - 32'd1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        bheN = 1'b1;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        decErr;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] shadow [2][2][WORDS];

  memdec_top #(.BANK_AW(AW)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .bheN(bheN), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .decErr(decErr)
  );

  always #10 clk = ~clk;

  function automatic logic [19:0] mk(input logic [3:0] tag, input int k, input logic odd);
    return {tag, FILL | 16'(k << 1) | 16'(odd)};
  endfunction

  function automatic logic [7:0] romB(input logic odd, input int k);
    return 8'(k) ^ (odd ? 8'hC3 : 8'h3C);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [19:0] a, input logic bh, input logic r, input logic w,
                     input logic [15:0] d);
    @(negedge clk);
    addr = a; bheN = bh; rdEn = r; wrEn = w; wrData = d;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic ramWrite(input int p, input int k, input logic a0, input logic bh,
                          input logic [15:0] d);
    acc(mk(p == 0 ? 4'hD : 4'hE, k, a0), bh, 1'b0, 1'b1, d);
    if (!a0) shadow[p][0][k] = d[7:0];
    if (!bh) shadow[p][1][k] = d[15:8];
  endtask

  task automatic ramReadWord(input int p, input int k, input string req);
    acc(mk(p == 0 ? 4'hD : 4'hE, k, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0);
    chk(req, rdData, {shadow[p][1][k], shadow[p][0][k]});
  endtask

  task automatic ramSweep(input string req);
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < WORDS; k++) ramReadWord(p, k, req);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset rdData", rdData, 16'hFFFF);
    chk("R8 reset decErr", {15'b0, decErr}, 16'h0);
    rstN = 1'b1;

    // R10 reset fetch address lies in ROM
    begin
      int k10 = (20'hFFFF0 >> 1) & (WORDS - 1);
      acc(20'hFFFF0, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R10 reset fetch", rdData, {romB(1'b1, k10), romB(1'b0, k10)});
      chk("R10 no error", {15'b0, decErr}, 16'h0);
    end

    // R6 ROM sweep, word and single-lane
    for (int k = 0; k < WORDS; k++) begin
      acc(mk(4'hF, k, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R6 rom word", rdData, {romB(1'b1, k), romB(1'b0, k)});
      acc(mk(4'hF, k, 1'b1), 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R2 rom odd byte", rdData, {romB(1'b1, k), 8'hFF});
    end

    // R5 word writes to both RAM pairs, R1 read back
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < WORDS; k++)
        ramWrite(p, k, 1'b0, 1'b0, 16'((k * 37 + p * 91 + 5) * 257 + k));
    ramSweep("R1 R5 word write");

    // R5 byte writes to pair 0 only
    for (int k = 0; k < WORDS; k++) begin
      if (k % 2 == 0) ramWrite(0, k, 1'b0, 1'b1, 16'hA500 | 16'(k));
      else            ramWrite(0, k, 1'b1, 1'b0, 16'h005A | 16'(k << 8));
    end
    ramSweep("R5 byte lanes");

    // R2 R3 single-lane reads from RAM
    for (int k = 0; k < WORDS; k += 7) begin
      acc(mk(4'hE, k, 1'b1), 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R3 odd-only read", rdData, {shadow[1][1][k], 8'hFF});
      acc(mk(4'hD, k, 1'b0), 1'b1, 1'b1, 1'b0, 16'h0);
      chk("R3 even-only read", rdData, {8'hFF, shadow[0][0][k]});
      acc(mk(4'hD, k, 1'b1), 1'b1, 1'b1, 1'b0, 16'h0);
      chk("R7 no lane read", rdData, 16'hFFFF);
    end

    // R7 writes with no lane enabled
    for (int k = 0; k < WORDS; k += 5) begin
      acc(mk(4'hD, k, 1'b1), 1'b1, 1'b0, 1'b1, 16'h1234);
      acc(mk(4'hE, k, 1'b1), 1'b1, 1'b0, 1'b1, 16'h4321);
    end
    ramSweep("R7 no-lane write");

    // R6 ROM writes ignored
    acc(mk(4'hF, 3, 1'b0), 1'b0, 1'b0, 1'b1, 16'h55AA);
    chk("R6 rom write no error", {15'b0, decErr}, 16'h0);
    acc(mk(4'hF, 3, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R6 rom unchanged", rdData, {romB(1'b1, 3), romB(1'b0, 3)});

    // R1 R8 unmapped tags and holes
    for (int t = 0; t < 13; t++) begin
      acc({4'(t), 16'hFFFE}, 1'b0, 1'b1, 1'b0, 16'h0);
      chk("R1 unmapped tag read", rdData, 16'hFFFF);
      chk("R8 error pulse", {15'b0, decErr}, 16'h1);
      @(negedge clk);
      chk("R8 error one cycle", {15'b0, decErr}, 16'h0);
    end
    acc(20'hF0000, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R1 rom hole read", rdData, 16'hFFFF);
    chk("R8 rom hole error", {15'b0, decErr}, 16'h1);
    acc(20'hD0000, 1'b0, 1'b0, 1'b1, 16'hDEAD);
    chk("R8 write hole error", {15'b0, decErr}, 16'h1);
    acc(20'hE0002, 1'b0, 1'b0, 1'b1, 16'hBEEF);
    ramSweep("R1 hole write harmless");

    // R9 read and write in the same cycle
    begin
      logic [15:0] oldW;
      oldW = {shadow[1][1][9], shadow[1][0][9]};
      acc(mk(4'hE, 9, 1'b0), 1'b0, 1'b1, 1'b1, 16'hC0DE);
      chk("R9 read sees old", rdData, oldW);
      shadow[1][0][9] = 8'hDE; shadow[1][1][9] = 8'hC0;
      ramReadWord(1, 9, "R9 write landed");
    end

    // R4 hold across idle cycles
    begin
      logic [15:0] held;
      held = rdData;
      repeat (3) @(negedge clk);
      chk("R4 hold", rdData, held);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule